// File: doc/BRIEF.md
# Parallel DAC Latch Controller

This block is the digital front end of a parallel-bus digital-to-analog converter. A host writes a data word over a bidirectional bus into a staging register and can read that word back for diagnostics. A separate conversion register feeds the converter core. An active-low load strobe copies the staging register into the conversion register. An active-low clear strobe forces the conversion register to a preset code. The read/write level at the time of the clear picks the code: all-zeros gives zero volts in unipolar operation, and midscale gives zero volts in bipolar operation.

The bus cycle signals (chip select, read/write, data) are sampled directly on the block clock. The load and clear strobes are asynchronous control pins. They pass through a parameterised synchronizer, and the read/write line travels through the same synchronizer alongside them, so the clear code is chosen by the read/write level that matches the clear. The tri-state bus is modelled as separate data-in, data-out and output-enable ports.

Top module: `dac_bus_latch`

## Requirements
- R1: After reset both the staging register and the conversion register hold 0x0000, and `bus_oe` is low.
- R2: While `cs_n` is high, `bus_oe` is low and the staging register keeps its value whatever `rw` and `bus_din` do.
- R3: At a rising clock edge where `cs_n` is low and `rw` is low, `bus_din` is stored in the staging register.
- R4: While `cs_n` is low and `rw` is high, `bus_oe` is high and `bus_dout` carries the staging register. `bus_oe` falls in the same cycle that `cs_n` rises.
- R5: `ld_n` held low for one cycle copies the staging register into `conv_code`. The new value is visible SYNC_STAGES+1 clock edges after the strobe is applied.
- R6: `clr_n` held low with `rw` low loads 0x0000 into `conv_code`, with the same latency as R5.
- R7: `clr_n` held low with `rw` high loads midscale into `conv_code`, which is only the most significant bit set (0x8000 for 16 bits), with the same latency as R5.
- R8: When `clr_n` and `ld_n` are both low in the same cycle, the clear code wins.
- R9: A clear leaves the staging register unchanged.
- R10: While neither strobe is active, `conv_code` holds its value, including across writes to the staging register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| rw | input | 1 | 1 = read back, 0 = write; also selects the clear code |
| ld_n | input | 1 | Load strobe, active low, asynchronous |
| clr_n | input | 1 | Clear strobe, active low, asynchronous |
| bus_din | input | DATA_W | Data bus input half |
| bus_dout | output | DATA_W | Data bus output half (staging register during readback) |
| bus_oe | output | 1 | Bus driver enable |
| conv_code | output | DATA_W | Code presented to the converter core |

## Verification
A bus write lands in the staging register at the next rising edge. Readback data and the output enable follow chip select and read/write within the same cycle. A load or clear shows up on `conv_code` exactly SYNC_STAGES+1 edges after the strobe is applied. The driver tasks record each expected value with the exact cycle number at which it is due, computed from these latencies. The monitor compares it in that cycle, a quarter period after the falling edge. An expectation that is still pending after its cycle has passed counts as a failure, so a result that arrives early or late is caught as well as a wrong value.

// File: rtl/dacl_pkg.sv
package dacl_pkg;

   // Control word carried through the strobe synchronizer
   typedef struct packed {
      logic rw;
      logic ld_n;
      logic clr_n;
   } strobe_t;

   localparam int STROBE_W = $bits(strobe_t);

   // Idle value: strobes inactive (high), rw low
   localparam strobe_t STROBE_IDLE = '{rw: 1'b0, ld_n: 1'b1, clr_n: 1'b1};

endpackage

// File: rtl/dacl_sync.sv
module dacl_sync #(
   parameter int               W       = 3,
   parameter int               STAGES  = 2,
   parameter logic [W-1:0]     RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   if (STAGES < 1) begin : g_bad_stages
      $error("dacl_sync: STAGES must be at least 1");
   end
   if (W < 1) begin : g_bad_width
      $error("dacl_sync: W must be at least 1");
   end

   logic [W-1:0] stg [STAGES];

   for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg[g] <= RST_VAL;
            else        stg[g] <= d;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg[g] <= RST_VAL;
            else        stg[g] <= stg[g-1];
         end
      end
   end

   assign q = stg[STAGES-1];

endmodule

// File: rtl/dacl_input_reg.sv
module dacl_input_reg #(
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs_n,
   input  logic              rw,
   input  logic [DATA_W-1:0] din,
   output logic [DATA_W-1:0] stage_q,
   output logic [DATA_W-1:0] dout,
   output logic              oe
);

   logic wr_en;
   logic rd_en;

   assign wr_en = !cs_n && !rw;
   assign rd_en = !cs_n && rw;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     stage_q <= '0;
      else if (wr_en) stage_q <= din;
   end

   assign oe   = rd_en;
   assign dout = rd_en ? stage_q : '0;

   // R2
   stage_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cs_n |=> $stable(stage_q));

   // R3
   bus_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!cs_n && !rw) |=> (stage_q == $past(din)));

   // R4
   readback_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
      oe |-> (dout == stage_q));

endmodule

// File: rtl/dacl_conv_reg.sv
module dacl_conv_reg #(
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_act,
   input  logic              clear_act,
   input  logic              clear_rw,
   input  logic [DATA_W-1:0] src,
   output logic [DATA_W-1:0] code_q
);

   localparam logic [DATA_W-1:0] CODE_ZERO = '0;
   localparam logic [DATA_W-1:0] CODE_MID  = {1'b1, {(DATA_W-1){1'b0}}};

   logic [DATA_W-1:0] clear_code;

   assign clear_code = clear_rw ? CODE_MID : CODE_ZERO;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         code_q <= CODE_ZERO;
      else if (clear_act) code_q <= clear_code;
      else if (load_act)  code_q <= src;
   end

   // R6
   clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clear_act && !clear_rw) |=> (code_q == '0));

   // R7
   clear_mid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clear_act && clear_rw) |=> (code_q[DATA_W-1] && ($countones(code_q) == 1)));

   // R5
   load_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (load_act && !clear_act) |=> (code_q == $past(src)));

   // R10
   code_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!load_act && !clear_act) |=> $stable(code_q));

endmodule

// File: rtl/dac_bus_latch.sv
module dac_bus_latch #(
   parameter int DATA_W      = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs_n,
   input  logic              rw,
   input  logic              ld_n,
   input  logic              clr_n,
   input  logic [DATA_W-1:0] bus_din,
   output logic [DATA_W-1:0] bus_dout,
   output logic              bus_oe,
   output logic [DATA_W-1:0] conv_code
);
   import dacl_pkg::*;

   if (DATA_W < 2) begin : g_bad_width
      $error("dac_bus_latch: DATA_W must be at least 2");
   end
   if (SYNC_STAGES < 1) begin : g_bad_sync
      $error("dac_bus_latch: SYNC_STAGES must be at least 1");
   end

   logic [DATA_W-1:0] stage_q;
   strobe_t           strobe_raw;
   strobe_t           strobe_s;

   assign strobe_raw = '{rw: rw, ld_n: ld_n, clr_n: clr_n};

   dacl_input_reg #(.DATA_W(DATA_W)) u_input (
      .clk     (clk),
      .rst_n   (rst_n),
      .cs_n    (cs_n),
      .rw      (rw),
      .din     (bus_din),
      .stage_q (stage_q),
      .dout    (bus_dout),
      .oe      (bus_oe)
   );

   dacl_sync #(
      .W       (STROBE_W),
      .STAGES  (SYNC_STAGES),
      .RST_VAL (STROBE_IDLE)
   ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (strobe_raw),
      .q     (strobe_s)
   );

   dacl_conv_reg #(.DATA_W(DATA_W)) u_conv (
      .clk       (clk),
      .rst_n     (rst_n),
      .load_act  (!strobe_s.ld_n),
      .clear_act (!strobe_s.clr_n),
      .clear_rw  (strobe_s.rw),
      .src       (stage_q),
      .code_q    (conv_code)
   );

   // R8
   clear_priority_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!strobe_s.clr_n && !strobe_s.ld_n && !strobe_s.rw) |=> (conv_code == '0));

   // R9
   clear_keeps_stage_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!strobe_s.clr_n && cs_n) |=> $stable(stage_q));

   // R4
   oe_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cs_n |-> !bus_oe);

endmodule

// File: tb/dac_bus_latch_tb.sv
module dac_bus_latch_tb_top;

   localparam int CLK_PERIOD = 10;
   localparam int DATA_W     = 16;
   localparam int SYNC       = 2;
   localparam int LAT        = SYNC + 1;

   localparam int SEL_CONV = 0;
   localparam int SEL_DOUT = 1;
   localparam int SEL_OE   = 2;

   typedef struct {
      int                due;
      int                sel;
      logic [DATA_W-1:0] val;
      string             tag;
   } exp_t;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              cs_n = 1'b1;
   logic              rw = 1'b0;
   logic              ld_n = 1'b1;
   logic              clr_n = 1'b1;
   logic [DATA_W-1:0] bus_din = '0;
   logic [DATA_W-1:0] bus_dout;
   logic              bus_oe;
   logic [DATA_W-1:0] conv_code;

   int   cyc = 0;
   int   checks = 0;
   int   failures = 0;
   exp_t sb[$];

   always #(CLK_PERIOD/2) clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   dac_bus_latch #(.DATA_W(DATA_W), .SYNC_STAGES(SYNC)) dut_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .cs_n      (cs_n),
      .rw        (rw),
      .ld_n      (ld_n),
      .clr_n     (clr_n),
      .bus_din   (bus_din),
      .bus_dout  (bus_dout),
      .bus_oe    (bus_oe),
      .conv_code (conv_code)
   );

   task automatic expect_at(int due, int sel, logic [DATA_W-1:0] val, string tag);
      exp_t e;
      e.due = due; e.sel = sel; e.val = val; e.tag = tag;
      sb.push_back(e);
   endtask

   // Monitor: compare due items a quarter period after the falling edge
   always @(negedge clk) begin
      #(CLK_PERIOD/4);
      for (int i = sb.size() - 1; i >= 0; i--) begin
         if (sb[i].due == cyc) begin
            logic [DATA_W-1:0] act;
            case (sb[i].sel)
               SEL_CONV: act = conv_code;
               SEL_DOUT: act = bus_dout;
               default:  act = {{(DATA_W-1){1'b0}}, bus_oe};
            endcase
            checks++;
            if (act !== sb[i].val) begin
               failures++;
               $display("FAIL %s sel=%0d cyc=%0d actual=%h expected=%h",
                        sb[i].tag, sb[i].sel, cyc, act, sb[i].val);
            end
            sb.delete(i);
         end else if (sb[i].due < cyc) begin
            checks++;
            failures++;
            $display("FAIL %s missed cyc=%0d actual=none expected=%h",
                     sb[i].tag, sb[i].due, sb[i].val);
            sb.delete(i);
         end
      end
   end

   task automatic write_word(logic [DATA_W-1:0] v);
      @(negedge clk);
      cs_n = 1'b0; rw = 1'b0; bus_din = v;
      @(negedge clk);
      cs_n = 1'b1; rw = 1'b0; bus_din = ~v;
   endtask

   task automatic read_check(logic [DATA_W-1:0] v, string tag);
      @(negedge clk);
      cs_n = 1'b0; rw = 1'b1;
      expect_at(cyc, SEL_DOUT, v, tag);
      expect_at(cyc, SEL_OE, 1, tag);
      @(negedge clk);
      cs_n = 1'b1; rw = 1'b0;
      expect_at(cyc, SEL_OE, 0, "R4");
   endtask

   task automatic strobe(logic ld, logic clr, logic rwv, logic [DATA_W-1:0] v, string tag);
      @(negedge clk);
      ld_n = !ld; clr_n = !clr; rw = rwv;
      expect_at(cyc + LAT, SEL_CONV, v, tag);
      @(negedge clk);
      ld_n = 1'b1; clr_n = 1'b1; rw = 1'b0;
      repeat (LAT) @(negedge clk);
   endtask

   task automatic hold_check(logic [DATA_W-1:0] v, string tag);
      @(negedge clk);
      expect_at(cyc, SEL_CONV, v, tag);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1: reset state
      @(negedge clk);
      expect_at(cyc, SEL_CONV, 16'h0000, "R1");
      expect_at(cyc, SEL_OE, 0, "R1");
      read_check(16'h0000, "R1");

      // R3 / R4: write then read back
      write_word(16'h1234);
      read_check(16'h1234, "R3");

      // R2: bus activity with chip select high
      @(negedge clk);
      cs_n = 1'b1; rw = 1'b0; bus_din = 16'hFFFF;
      expect_at(cyc, SEL_OE, 0, "R2");
      @(negedge clk);
      rw = 1'b1; bus_din = 16'h5A5A;
      expect_at(cyc, SEL_OE, 0, "R2");
      @(negedge clk);
      rw = 1'b0;
      read_check(16'h1234, "R2");

      // R5: load
      strobe(1'b1, 1'b0, 1'b0, 16'h1234, "R5");
      hold_check(16'h1234, "R10");

      // R10: write without load keeps conversion code
      write_word(16'hBEEF);
      hold_check(16'h1234, "R10");
      strobe(1'b1, 1'b0, 1'b0, 16'hBEEF, "R5");

      // R6 / R9
      strobe(1'b0, 1'b1, 1'b0, 16'h0000, "R6");
      read_check(16'hBEEF, "R9");

      // R7
      strobe(1'b0, 1'b1, 1'b1, 16'h8000, "R7");
      hold_check(16'h8000, "R10");
      read_check(16'hBEEF, "R9");

      // R8: clear beats load, both polarities
      strobe(1'b1, 1'b1, 1'b0, 16'h0000, "R8");
      strobe(1'b1, 1'b1, 1'b1, 16'h8000, "R8");

      // More patterns
      write_word(16'hFFFF);
      read_check(16'hFFFF, "R3");
      strobe(1'b1, 1'b0, 1'b0, 16'hFFFF, "R5");
      write_word(16'h0001);
      strobe(1'b1, 1'b0, 1'b1, 16'h0001, "R5");
      strobe(1'b0, 1'b1, 1'b0, 16'h0000, "R6");

      repeat (LAT + 2) @(negedge clk);
      #(CLK_PERIOD/2);
      if (sb.size() != 0) begin
         checks++;
         failures++;
         $display("FAIL pending actual=%0d expected=0", sb.size());
      end
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule